// File: doc/BRIEF.md
# Stepped User Clock Controller

This block produces the clock-enable that gates the clock of a user logic region. Software sets a mode and issues commands through a small write-only register port, and the enable then follows one of four policies. In free mode it stays high. In step mode it stays high for a programmed number of cycles. In FIFO-triggered mode every push into the input FIFO produces a fixed burst of enabled cycles. In halt-watch mode it runs freely until a user-logic halt line falls, and then it allows three more enabled cycles.

A one-cycle completion pulse marks the end of every counted burst and is meant for an interrupt controller. A host preempt input suspends the enable while it is held, and counting resumes where it left off. The present activity and the number of enabled cycles still owed are brought out as status outputs. Frequency synthesis and the clock buffer itself sit outside this block.

Register port: address 0 (configuration) takes the mode in bits [1:0] (0 free, 1 step, 2 FIFO-triggered, 3 halt-watch) and the halt-line enable mask in bits [2+:NUM_PE]. Address 1 takes a step count. Address 2 takes the burst length that each FIFO push produces. Address 3 takes commands: bit 0 stops, and bit 1 starts free running. A write takes effect on the clock edge where it is presented.

Top module: `uclk_step_ctrl`

## Requirements
- R1: After synchronous reset, clk_en_o, running_o and step_done_o are 0 and remaining_o is 0.
- R2: In mode 0, a write of bit 1 to address 3 raises clk_en_o from the next cycle on, and it stays high until a stop.
- R3: In mode 1, writing a nonzero N to address 1 gives exactly N consecutive cycles with clk_en_o high, starting the cycle after the write. The enable then returns low.
- R4: Writing 0 to address 1 starts nothing: clk_en_o and running_o stay 0.
- R5: step_done_o is high for exactly one cycle, the cycle after the last enabled cycle of a step or FIFO burst. It is never high at any other time.
- R6: In mode 2, each fifo_push_i pulse while idle produces exactly L enabled cycles, where L is the value last written to address 2. A push while L is 0 has no effect.
- R7: A push that arrives during a running FIFO burst adds L to the remaining count. The burst continues without a gap, and its total equals the sum of the lengths.
- R8: In mode 3 after a run command, a falling edge on a halt_i bit whose mask bit is set is followed by exactly three more enabled cycles after the cycle in which the edge is seen. The enable then stops, with no done pulse.
- R9: A falling edge on a halt_i bit whose mask bit is clear leaves free running undisturbed.
- R10: A write of bit 0 to address 3 forces clk_en_o, running_o and remaining_o to 0 from the next cycle, in any mode and any state.
- R11: While preempt_i is high, clk_en_o is low and remaining_o holds its value. After release, the burst completes with its full count.
- R12: running_o is high whenever a run or a burst is active. During a burst, remaining_o shows the number of enabled cycles still owed, including the current one, and falls by one on each enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| fifo_push_i | input | 1 | One-cycle pulse per input-FIFO write |
| halt_i | input | NUM_PE | Halt request lines from user logic, active on falling edge |
| preempt_i | input | 1 | Host preempt; suspends the enable while high |
| clk_en_o | output | 1 | Gating enable for the user clock |
| step_done_o | output | 1 | One-cycle burst-complete interrupt source |
| running_o | output | 1 | Status: a run or burst is active |
| remaining_o | output | CNT_W | Status: enabled cycles still owed |

## Verification
Step bursts are driven with a zero count, with a short count, and with a count interrupted by preemption. Together these separate a missing start, an off-by-one burst length and a counter that keeps running while gated. FIFO bursts are tried with a single push, with a second push landing mid-burst, and with a zero length. These show whether overlapping requests accumulate or get lost. Halt-watch is exercised with an enabled line and with a masked line, which confirms both the three-cycle tail and the masking. A stop issued in the middle of a long burst shows that the stop is immediate and that no done pulse leaks out.

// File: rtl/uclk_pkg.sv
package uclk_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_STEP = 2'd1,
        MODE_FIFO = 2'd2,
        MODE_HALT = 2'd3
    } uclk_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FREE  = 2'd1,
        ST_BURST = 2'd2,
        ST_TAIL  = 2'd3
    } uclk_state_e;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_STEP = 2'd1;
    localparam logic [1:0] ADDR_FLEN = 2'd2;
    localparam logic [1:0] ADDR_CTRL = 2'd3;

    localparam int CTRL_STOP_BIT = 0;
    localparam int CTRL_RUN_BIT  = 1;
    localparam int CFG_MASK_LSB  = 2;

    typedef struct packed {
        logic stop;
        logic run;
        logic step_wr;
    } uclk_cmd_t;

    function automatic logic mode_allows_run(input uclk_mode_e m);
        return (m == MODE_FREE) || (m == MODE_HALT);
    endfunction

endpackage

// File: rtl/uclk_cfg_regs.sv
module uclk_cfg_regs
    import uclk_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_PE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output uclk_mode_e        mode,
    output logic [NUM_PE-1:0] halt_mask,
    output logic [CNT_W-1:0]  fifo_len,
    output logic [CNT_W-1:0]  step_val,
    output uclk_cmd_t         cmd
);

    logic wr_cfg, wr_flen, wr_ctrl;

    assign wr_cfg  = reg_wr && (reg_addr == ADDR_CFG);
    assign wr_flen = reg_wr && (reg_addr == ADDR_FLEN);
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= MODE_FREE;
            halt_mask <= '0;
            fifo_len  <= '0;
        end else begin
            if (wr_cfg) begin
                mode      <= uclk_mode_e'(reg_wdata[1:0]);
                halt_mask <= reg_wdata[CFG_MASK_LSB +: NUM_PE];
            end
            if (wr_flen) begin
                fifo_len <= reg_wdata;
            end
        end
    end

    always_comb begin
        cmd.stop    = wr_ctrl && reg_wdata[CTRL_STOP_BIT];
        cmd.run     = wr_ctrl && reg_wdata[CTRL_RUN_BIT] && !reg_wdata[CTRL_STOP_BIT];
        cmd.step_wr = reg_wr && (reg_addr == ADDR_STEP);
    end

    assign step_val = reg_wdata;

endmodule

// File: rtl/uclk_halt_detect.sv
module uclk_halt_detect #(
    parameter int NUM_PE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PE-1:0] halt_i,
    input  logic [NUM_PE-1:0] halt_mask,
    output logic              halt_fall
);

    logic [NUM_PE-1:0] fall_vec;

    for (genvar g = 0; g < NUM_PE; g++) begin : g_line
        logic last_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                last_q <= 1'b0;
            end else begin
                last_q <= halt_i[g];
            end
        end
        assign fall_vec[g] = last_q && !halt_i[g] && halt_mask[g];
    end

    assign halt_fall = |fall_vec;

endmodule

// File: rtl/uclk_step_engine.sv
module uclk_step_engine
    import uclk_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int TAIL_N = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  uclk_mode_e       mode,
    input  uclk_cmd_t        cmd,
    input  logic [CNT_W-1:0] step_val,
    input  logic [CNT_W-1:0] fifo_len,
    input  logic             fifo_push,
    input  logic             halt_fall,
    input  logic             preempt,
    output logic             clk_en,
    output logic             running,
    output logic [CNT_W-1:0] remaining,
    output logic             done
);

    localparam logic [CNT_W-1:0] TAIL_LOAD = CNT_W'(TAIL_N);

    uclk_state_e      st_q, st_d;
    logic [CNT_W-1:0] rem_q, rem_d;
    logic             done_d;
    logic [CNT_W-1:0] cnt_dec;
    logic [CNT_W:0]   cnt_sum;
    logic [CNT_W-1:0] cnt_acc;

    assign running = (st_q != ST_IDLE);
    assign clk_en  = running && !preempt;

    always_comb begin
        cnt_dec = rem_q - CNT_W'(clk_en);
        cnt_sum = {1'b0, cnt_dec} + {1'b0, fifo_len};
        cnt_acc = cnt_sum[CNT_W] ? {CNT_W{1'b1}} : cnt_sum[CNT_W-1:0];
    end

    always_comb begin
        st_d   = st_q;
        rem_d  = rem_q;
        done_d = 1'b0;
        if (cmd.stop) begin
            st_d  = ST_IDLE;
            rem_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (cmd.run && mode_allows_run(mode)) begin
                        st_d = ST_FREE;
                    end else if (cmd.step_wr && mode == MODE_STEP && step_val != '0) begin
                        st_d  = ST_BURST;
                        rem_d = step_val;
                    end else if (fifo_push && mode == MODE_FIFO && fifo_len != '0) begin
                        st_d  = ST_BURST;
                        rem_d = fifo_len;
                    end
                end
                ST_FREE: begin
                    if (mode == MODE_HALT && halt_fall) begin
                        st_d  = ST_TAIL;
                        rem_d = TAIL_LOAD;
                    end
                end
                ST_BURST: begin
                    rem_d = cnt_dec;
                    if (mode == MODE_FIFO && fifo_push) begin
                        rem_d = cnt_acc;
                    end
                    if (mode == MODE_STEP && cmd.step_wr && step_val != '0) begin
                        rem_d = step_val;
                    end
                    if (rem_d == '0) begin
                        st_d   = ST_IDLE;
                        done_d = 1'b1;
                    end
                end
                ST_TAIL: begin
                    rem_d = cnt_dec;
                    if (rem_d == '0) begin
                        st_d = ST_IDLE;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            rem_q <= '0;
            done  <= 1'b0;
        end else begin
            st_q  <= st_d;
            rem_q <= rem_d;
            done  <= done_d;
        end
    end

    assign remaining = rem_q;

endmodule

// File: rtl/uclk_step_ctrl.sv
module uclk_step_ctrl
    import uclk_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_PE = 3,
    parameter int TAIL_N = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    input  logic              fifo_push_i,
    input  logic [NUM_PE-1:0] halt_i,
    input  logic              preempt_i,
    output logic              clk_en_o,
    output logic              step_done_o,
    output logic              running_o,
    output logic [CNT_W-1:0]  remaining_o
);

    uclk_mode_e        mode;
    logic [NUM_PE-1:0] halt_mask;
    logic [CNT_W-1:0]  fifo_len;
    logic [CNT_W-1:0]  step_val;
    uclk_cmd_t         cmd;
    logic              halt_fall;

    uclk_cfg_regs #(.CNT_W(CNT_W), .NUM_PE(NUM_PE)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .mode      (mode),
        .halt_mask (halt_mask),
        .fifo_len  (fifo_len),
        .step_val  (step_val),
        .cmd       (cmd)
    );

    uclk_halt_detect #(.NUM_PE(NUM_PE)) u_halt (
        .clk       (clk),
        .rst       (rst),
        .halt_i    (halt_i),
        .halt_mask (halt_mask),
        .halt_fall (halt_fall)
    );

    uclk_step_engine #(.CNT_W(CNT_W), .TAIL_N(TAIL_N)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .cmd       (cmd),
        .step_val  (step_val),
        .fifo_len  (fifo_len),
        .fifo_push (fifo_push_i),
        .halt_fall (halt_fall),
        .preempt   (preempt_i),
        .clk_en    (clk_en_o),
        .running   (running_o),
        .remaining (remaining_o),
        .done      (step_done_o)
    );

endmodule

// File: rtl/uclk_step_ctrl_chk.sv
module uclk_step_ctrl_chk #(
    parameter int CNT_W  = 16,
    parameter int NUM_PE = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [CNT_W-1:0]  reg_wdata,
    input logic              fifo_push_i,
    input logic [NUM_PE-1:0] halt_i,
    input logic              preempt_i,
    input logic              clk_en_o,
    input logic              step_done_o,
    input logic              running_o,
    input logic [CNT_W-1:0]  remaining_o
);

    logic stop_wr;
    assign stop_wr = reg_wr && (reg_addr == 2'd3) && reg_wdata[0];

    assert_en_implies_run_R2: assert property (@(posedge clk) disable iff (rst)
        clk_en_o |-> running_o);

    assert_zero_step_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1 && reg_wdata == '0 && !running_o && !fifo_push_i)
        |=> !running_o);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        step_done_o |=> !step_done_o);

    assert_done_after_en_R5: assert property (@(posedge clk) disable iff (rst)
        step_done_o |-> ($past(clk_en_o) && !running_o));

    assert_stop_now_R10: assert property (@(posedge clk) disable iff (rst)
        stop_wr |=> (!clk_en_o && !running_o && remaining_o == '0));

    assert_preempt_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        (preempt_i && remaining_o != '0 && !reg_wr && !fifo_push_i)
        |=> $stable(remaining_o));

    assert_count_down_R12: assert property (@(posedge clk) disable iff (rst)
        (clk_en_o && remaining_o > 1 && !reg_wr && !fifo_push_i)
        |=> (remaining_o == $past(remaining_o) - 1'b1));

endmodule

bind uclk_step_ctrl uclk_step_ctrl_chk #(.CNT_W(CNT_W), .NUM_PE(NUM_PE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .fifo_push_i (fifo_push_i),
    .halt_i      (halt_i),
    .preempt_i   (preempt_i),
    .clk_en_o    (clk_en_o),
    .step_done_o (step_done_o),
    .running_o   (running_o),
    .remaining_o (remaining_o)
);

// File: tb/uclk_step_ctrl_bench.sv
module uclk_step_ctrl_bench;

    localparam int CNT_W  = 16;
    localparam int NUM_PE = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [CNT_W-1:0]  reg_wdata = '0;
    logic              fifo_push_i = 1'b0;
    logic [NUM_PE-1:0] halt_i = '1;
    logic              preempt_i = 1'b0;
    logic              clk_en_o, step_done_o, running_o;
    logic [CNT_W-1:0]  remaining_o;

    uclk_step_ctrl #(.CNT_W(CNT_W), .NUM_PE(NUM_PE)) u_uclk_step_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .fifo_push_i(fifo_push_i), .halt_i(halt_i),
        .preempt_i(preempt_i), .clk_en_o(clk_en_o), .step_done_o(step_done_o),
        .running_o(running_o), .remaining_o(remaining_o)
    );

    always #10 clk = ~clk;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cnt_en  = 0;
    int    cnt_done = 0;
    bit    started = 1'b0;
    bit    finished = 1'b0;
    string phase = "R1";

    // reference model state
    bit          m_act, m_free, m_tail, m_done, m_en, m_fall, m_stop, m_run, m_stw;
    int          m_rem, m_mode, m_flen;
    logic [2:0]  m_mask, m_hq;

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            m_act = 0; m_free = 0; m_tail = 0; m_done = 0; m_rem = 0;
            m_mode = 0; m_flen = 0; m_mask = '0; m_hq = '0;
        end else begin
            m_en   = m_act && !preempt_i;
            m_fall = ((m_hq & ~halt_i & m_mask) != 3'b000);
            m_hq   = halt_i;
            m_done = 0;
            m_stop = reg_wr && reg_addr == 2'd3 && reg_wdata[0];
            m_run  = reg_wr && reg_addr == 2'd3 && reg_wdata[1];
            m_stw  = reg_wr && reg_addr == 2'd1 && reg_wdata != 0;
            if (m_stop) begin
                m_act = 0; m_free = 0; m_tail = 0; m_rem = 0;
            end else if (m_free) begin
                if (m_mode == 3 && m_fall) begin
                    m_free = 0; m_tail = 1; m_rem = 3;
                end
            end else if (m_act) begin
                if (m_en) m_rem = m_rem - 1;
                if (!m_tail && m_mode == 2 && fifo_push_i)
                    m_rem = (m_rem + m_flen > 65535) ? 65535 : m_rem + m_flen;
                if (!m_tail && m_mode == 1 && m_stw) m_rem = int'(reg_wdata);
                if (m_rem == 0) begin
                    if (!m_tail) m_done = 1;
                    m_act = 0; m_tail = 0;
                end
            end else begin
                if (m_run && (m_mode == 0 || m_mode == 3)) begin
                    m_act = 1; m_free = 1;
                end else if (m_mode == 1 && m_stw) begin
                    m_act = 1; m_rem = int'(reg_wdata);
                end else if (m_mode == 2 && fifo_push_i && m_flen != 0) begin
                    m_act = 1; m_rem = m_flen;
                end
            end
            if (reg_wr && reg_addr == 2'd0) begin
                m_mode = int'(reg_wdata[1:0]);
                m_mask = reg_wdata[4:2];
            end
            if (reg_wr && reg_addr == 2'd2) m_flen = int'(reg_wdata);
        end
    end

    // per-cycle comparison, away from both edges
    always @(negedge clk) begin
        #5;
        if (started && !finished) begin
            bit exp_en;
            exp_en = m_act && !preempt_i;
            n_tests++;
            if (clk_en_o !== exp_en || running_o !== m_act || step_done_o !== m_done
                || int'(remaining_o) != m_rem) begin
                n_fail++;
                $display("FAIL %s cycle model: en=%b run=%b done=%b rem=%0d expected en=%b run=%b done=%b rem=%0d",
                         phase, clk_en_o, running_o, step_done_o, remaining_o,
                         exp_en, m_act, m_done, m_rem);
            end
            if (clk_en_o === 1'b1) cnt_en++;
            if (step_done_o === 1'b1) cnt_done++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic push();
        @(negedge clk);
        fifo_push_i = 1'b1;
        @(negedge clk);
        fifo_push_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        cnt_en = 0;
        cnt_done = 0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        #6;
        phase = "R1";
        chk("R1 en after reset", int'(clk_en_o), 0);
        chk("R1 running after reset", int'(running_o), 0);
        chk("R1 remaining after reset", int'(remaining_o), 0);
        chk("R1 done after reset", int'(step_done_o), 0);

        phase = "R2";
        wr(2'd0, 16'd0);
        wr(2'd3, 16'd2);
        idle(5); #6;
        chk("R2 free run enable", int'(clk_en_o), 1);
        chk("R2 free run running", int'(running_o), 1);
        phase = "R10";
        wr(2'd3, 16'd1); #6;
        chk("R10 stop from free run", int'(clk_en_o), 0);

        phase = "R4";
        wr(2'd0, 16'd1);
        clr();
        wr(2'd1, 16'd0);
        idle(4);
        chk("R4 zero count enables", cnt_en, 0);
        chk("R4 zero count running", int'(running_o), 0);

        phase = "R3";
        clr();
        wr(2'd1, 16'd5); #6;
        chk("R12 remaining right after start", int'(remaining_o), 5);
        chk("R12 running during burst", int'(running_o), 1);
        idle(10);
        chk("R3 step burst length", cnt_en, 5);
        chk("R5 done pulses per step burst", cnt_done, 1);

        phase = "R11";
        clr();
        wr(2'd1, 16'd6);
        idle(2);
        preempt_i = 1'b1; #6;
        chk("R11 enable gated by preempt", int'(clk_en_o), 0);
        idle(3);
        preempt_i = 1'b0;
        idle(12);
        chk("R11 burst length across preempt", cnt_en, 6);

        phase = "R6";
        wr(2'd0, 16'd2);
        wr(2'd2, 16'd3);
        clr();
        push();
        idle(8);
        chk("R6 fifo burst length", cnt_en, 3);
        chk("R5 done per fifo burst", cnt_done, 1);

        phase = "R7";
        clr();
        push();
        idle(1);
        push();
        idle(12);
        chk("R7 accumulated burst length", cnt_en, 6);
        chk("R7 single done for merged burst", cnt_done, 1);

        phase = "R6";
        wr(2'd2, 16'd0);
        clr();
        push();
        idle(4);
        chk("R6 zero length push enables", cnt_en, 0);

        phase = "R8";
        halt_i = '1;
        wr(2'd0, 16'h000B);
        wr(2'd3, 16'd2);
        idle(3);
        @(negedge clk);
        halt_i[1] = 1'b0;
        #6;
        clr();
        idle(10);
        chk("R8 enabled cycles after halt edge", cnt_en, 3);
        chk("R8 no done after halt", cnt_done, 0);
        chk("R8 stopped after tail", int'(running_o), 0);
        halt_i = '1;

        phase = "R9";
        wr(2'd3, 16'd2);
        idle(2);
        @(negedge clk);
        halt_i[0] = 1'b0;
        idle(5); #6;
        chk("R9 masked halt line ignored", int'(clk_en_o), 1);
        wr(2'd3, 16'd1);
        halt_i = '1;

        phase = "R10";
        wr(2'd0, 16'd1);
        wr(2'd1, 16'd20);
        idle(3);
        wr(2'd3, 16'd1); #6;
        chk("R10 stop mid burst enable", int'(clk_en_o), 0);
        chk("R10 stop mid burst remaining", int'(remaining_o), 0);
        clr();
        idle(5);
        chk("R10 no enable after stop", cnt_en, 0);
        chk("R5 no done after stop", cnt_done, 0);

        idle(2);
        report();
    end

endmodule